// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the beam position and all raster control signals for a video output: horizontal and vertical counters, display-enable, data-window enable, horizontal and vertical sync, and blanking. It also emits per-axis pixel-repeat strobes, so that a pixel pipeline knows when to step to the next source pixel. Every timing value is one of nineteen 16-bit run-time parameters. Sync polarity and the repeat factors are parameters as well. No timing value is fixed in hardware.

A 2-bit output mode picks one of four built-in parameter sets: native 15.6 kHz, 640×480, 800×600 or 1024×768. A change of mode reloads the whole set at once and restarts the raster. After that the CPU can override single parameters through a small byte-wide port with four addresses: an index register, a low-byte register, a high-byte register and a read-only blanking status. Overrides go into a pending copy. The pending copy moves into the running timing only at a frame boundary, so no frame mixes two sets of values.

Top module: `raster_tmg`

## Requirements
- R1: After an asynchronous reset (rst_ni low), both counters read 0, the index register reads 0, and both the pending and the running copies hold the native preset listed in R11.
- R2: h_cnt_o counts up by one per clock from 0 to parameter 8 and then returns to 0. On each such return, v_cnt_o advances by one, or returns to 0 once it has reached parameter 9.
- R3: Horizontal sync is active while parameter 11 <= h_cnt_o <= parameter 12, both ends inclusive. Vertical sync is active while parameter 13 <= v_cnt_o <= parameter 14. The active level of hsync_o is high when parameter 15 is nonzero and low when it is zero. Parameter 16 sets the active level of vsync_o in the same way.
- R4: hblank_o is low only while parameter 0 <= h_cnt_o < parameter 1. vblank_o is low only while parameter 4 <= v_cnt_o < parameter 5. de_o is high exactly when both blanking outputs are low.
- R5: win_o is high exactly when parameter 2 <= h_cnt_o < parameter 3 and parameter 6 <= v_cnt_o < parameter 7.
- R6: Horizontal repeat factor f is parameter 17, and vertical repeat factor f is parameter 18. For each, 0 selects 1×, 1 selects 2× and any value of 2 or more selects 4×, with mask m = 0, 1 or 3 respectively. hstep_o is high when (h_cnt_o & m) == m. vstep_o is high when h_cnt_o equals parameter 8 and (v_cnt_o & m) == m. cols_o always shows parameter 10.
- R7: The CPU port uses addr_i 0 for the index, 1 for the low byte and 2 for the high byte of the pending value at the current index, and 3 for status. A write with wr_en_i high updates the addressed byte. rdata_o returns the index (addr 0), the pending byte (addr 1 or 2), or {6'b0, vblank_o, hblank_o} (addr 3). Writes to addr 3 have no effect.
- R8: A write to the index register with a value above 18 is ignored, and the index keeps its previous value.
- R9: Pending values take effect from the first cycle of the next frame. That is the cycle in which both counters show 0 after the wrap from parameter 8 and parameter 9. Until then the running frame keeps its old timing. A write in the last cycle of a frame applies one frame later.
- R10: When mode_i differs from the mode seen at the previous clock edge, the next cycle shows both counters at 0, with the pending and running copies loaded from the new preset. A CPU write in that same edge is lost.
- R11: The presets are listed by mode (0 native, 1 640×480, 2 800×600, 3 1024×768). Display area and data window both start at 0. The width/height values (0..320/0..200, 0..640/0..480, 0..800/0..600, 0..1024/0..768) set parameters 1, 3, 5 and 7. Line end (parameter 8) is 511, 799, 1055 or 1343. Frame end (parameter 9) is 259, 524, 627 or 805. Hsync spans 363–408, 656–752, 840–968 or 1048–1184. Vsync spans 219–223, 490–492, 601–605 or 771–777. Polarity (both axes) is 0, 0, 1 or 0. The horizontal factor is 0, 1, 1 or 2, and the vertical factor is 0, 1, 2 or 2. Parameter 10 is 40 in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Output mode; a change reloads presets |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | 2 | CPU register address |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | CPU read data |
| h_cnt_o | output | 16 | Horizontal position |
| v_cnt_o | output | 16 | Vertical position |
| hsync_o | output | 1 | Horizontal sync, polarity from parameter 15 |
| vsync_o | output | 1 | Vertical sync, polarity from parameter 16 |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| de_o | output | 1 | Inside the display area |
| win_o | output | 1 | Inside the data window |
| hstep_o | output | 1 | Advance source pixel horizontally |
| vstep_o | output | 1 | Advance source row, on the last pixel of a line |
| cols_o | output | 16 | Column count parameter |

## Verification
A wrong counter or a stale running copy shows within one line as a shifted sync or blanking edge, or as a line of the wrong length. A lost copy at the frame boundary shows from the first cycle of the next frame. Pending-copy corruption can be seen at once through the byte readback, before it ever reaches the raster. Because every cycle is compared against a cycle-accurate model, a fault surfaces in the first cycle where its state differs, not at the end of a frame.

// File: rtl/raster_tmg_pkg.sv
package raster_tmg_pkg;
  localparam int unsigned PW   = 16;
  localparam int unsigned NPAR = 19;
  localparam int unsigned SELW = $clog2(NPAR);
  localparam int unsigned AW   = 2;
  localparam int unsigned DW   = 8;

  typedef logic [PW-1:0] word_t;
  typedef logic [NPAR-1:0][PW-1:0] prm_arr_t;

  // parameter index positions (decoded by position)
  localparam int unsigned P_HDS = 0,  P_HDE = 1,  P_HWS = 2,  P_HWE = 3;
  localparam int unsigned P_VDS = 4,  P_VDE = 5,  P_VWS = 6,  P_VWE = 7;
  localparam int unsigned P_HEND = 8, P_VEND = 9, P_COLS = 10;
  localparam int unsigned P_HSS = 11, P_HSE = 12, P_VSS = 13, P_VSE = 14;
  localparam int unsigned P_HPOL = 15, P_VPOL = 16, P_HREP = 17, P_VREP = 18;

  localparam logic [1:0] ADDR_SEL = 2'd0, ADDR_LO = 2'd1, ADDR_HI = 2'd2, ADDR_STAT = 2'd3;

  function automatic word_t preset_val(input logic [1:0] m, input int unsigned idx);
    word_t hd, vd, he, ve, hs0, hs1, vs0, vs1, pol, hr, vr;
    case (m)
      2'd0: begin hd=16'd320;  vd=16'd200; he=16'd511;  ve=16'd259; hs0=16'd363;  hs1=16'd408;
                  vs0=16'd219; vs1=16'd223; pol=16'd0; hr=16'd0; vr=16'd0; end
      2'd1: begin hd=16'd640;  vd=16'd480; he=16'd799;  ve=16'd524; hs0=16'd656;  hs1=16'd752;
                  vs0=16'd490; vs1=16'd492; pol=16'd0; hr=16'd1; vr=16'd1; end
      2'd2: begin hd=16'd800;  vd=16'd600; he=16'd1055; ve=16'd627; hs0=16'd840;  hs1=16'd968;
                  vs0=16'd601; vs1=16'd605; pol=16'd1; hr=16'd1; vr=16'd2; end
      default: begin hd=16'd1024; vd=16'd768; he=16'd1343; ve=16'd805; hs0=16'd1048; hs1=16'd1184;
                  vs0=16'd771; vs1=16'd777; pol=16'd0; hr=16'd2; vr=16'd2; end
    endcase
    case (idx)
      P_HDE, P_HWE:   return hd;
      P_VDE, P_VWE:   return vd;
      P_HEND:         return he;
      P_VEND:         return ve;
      P_COLS:         return 16'd40;
      P_HSS:          return hs0;
      P_HSE:          return hs1;
      P_VSS:          return vs0;
      P_VSE:          return vs1;
      P_HPOL, P_VPOL: return pol;
      P_HREP:         return hr;
      P_VREP:         return vr;
      default:        return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/raster_tmg_cnt.sv
module raster_tmg_cnt
  import raster_tmg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  restart_i,
  input  word_t h_end_i,
  input  word_t v_end_i,
  output word_t h_o,
  output word_t v_o,
  output logic  frame_wrap_o
);
  word_t h_q, v_q;
  logic  h_last, v_last;

  assign h_last       = h_q >= h_end_i;
  assign v_last       = v_q >= v_end_i;
  assign frame_wrap_o = h_last && v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (restart_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_last) begin
      h_q <= '0;
      v_q <= v_last ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;
endmodule

// File: rtl/raster_tmg_regs.sv
module raster_tmg_regs
  import raster_tmg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            frame_wrap_i,
  output logic            reload_o,
  output logic [SELW-1:0] sel_o,
  output word_t           pend_o,
  output prm_arr_t        live_o
);
  logic [1:0]      mode_q;
  logic [SELW-1:0] sel_q;
  word_t           pend_q [NPAR];
  word_t           live_q [NPAR];
  logic            wr_sel, wr_lo, wr_hi;

  assign reload_o = mode_i != mode_q;
  assign wr_sel   = wr_en_i && addr_i == ADDR_SEL;
  assign wr_lo    = wr_en_i && addr_i == ADDR_LO;
  assign wr_hi    = wr_en_i && addr_i == ADDR_HI;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 2'd0;
      sel_q  <= '0;
    end else if (reload_o) begin
      mode_q <= mode_i;
    end else if (wr_sel && wdata_i < DW'(NPAR)) begin
      sel_q <= wdata_i[SELW-1:0];
    end
  end

  for (genvar i = 0; i < NPAR; i++) begin : g_prm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= preset_val(2'd0, i);
        live_q[i] <= preset_val(2'd0, i);
      end else if (reload_o) begin
        pend_q[i] <= preset_val(mode_i, i);
        live_q[i] <= preset_val(mode_i, i);
      end else begin
        if (wr_lo && sel_q == SELW'(i)) pend_q[i][7:0]  <= wdata_i;
        if (wr_hi && sel_q == SELW'(i)) pend_q[i][15:8] <= wdata_i;
        // old pending value moves at the wrap edge
        if (frame_wrap_i) live_q[i] <= pend_q[i];
      end
    end
    assign live_o[i] = live_q[i];
  end

  always_comb begin
    pend_o = '0;
    for (int j = 0; j < NPAR; j++)
      if (sel_q == SELW'(j)) pend_o = pend_q[j];
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/raster_tmg_dec.sv
module raster_tmg_dec
  import raster_tmg_pkg::*;
(
  input  word_t    h_i,
  input  word_t    v_i,
  input  prm_arr_t prm_i,
  output logic     hsync_o,
  output logic     vsync_o,
  output logic     hblank_o,
  output logic     vblank_o,
  output logic     de_o,
  output logic     win_o,
  output logic     hstep_o,
  output logic     vstep_o
);
  function automatic logic [1:0] rep_mask(input word_t f);
    return (f == 16'd0) ? 2'b00 : (f == 16'd1) ? 2'b01 : 2'b11;
  endfunction

  logic       h_disp, v_disp, h_sact, v_sact;
  logic [1:0] hm, vm;

  assign h_disp = h_i >= prm_i[P_HDS] && h_i < prm_i[P_HDE];
  assign v_disp = v_i >= prm_i[P_VDS] && v_i < prm_i[P_VDE];
  assign h_sact = h_i >= prm_i[P_HSS] && h_i <= prm_i[P_HSE];
  assign v_sact = v_i >= prm_i[P_VSS] && v_i <= prm_i[P_VSE];

  assign hsync_o  = h_sact ? (|prm_i[P_HPOL]) : !(|prm_i[P_HPOL]);
  assign vsync_o  = v_sact ? (|prm_i[P_VPOL]) : !(|prm_i[P_VPOL]);
  assign hblank_o = !h_disp;
  assign vblank_o = !v_disp;
  assign de_o     = h_disp && v_disp;
  assign win_o    = h_i >= prm_i[P_HWS] && h_i < prm_i[P_HWE] &&
                    v_i >= prm_i[P_VWS] && v_i < prm_i[P_VWE];

  assign hm      = rep_mask(prm_i[P_HREP]);
  assign vm      = rep_mask(prm_i[P_VREP]);
  assign hstep_o = (h_i[1:0] & hm) == hm;
  assign vstep_o = (h_i == prm_i[P_HEND]) && ((v_i[1:0] & vm) == vm);
endmodule

// File: rtl/raster_tmg.sv
module raster_tmg
  import raster_tmg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [15:0]   h_cnt_o,
  output logic [15:0]   v_cnt_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          de_o,
  output logic          win_o,
  output logic          hstep_o,
  output logic          vstep_o,
  output logic [15:0]   cols_o
);
  logic            reload, frame_wrap;
  logic [SELW-1:0] sel;
  word_t           pend, h_cnt, v_cnt;
  prm_arr_t        live;

  raster_tmg_regs u_regs (
    .clk_i, .rst_ni, .mode_i, .wr_en_i, .addr_i, .wdata_i,
    .frame_wrap_i(frame_wrap), .reload_o(reload), .sel_o(sel),
    .pend_o(pend), .live_o(live)
  );

  raster_tmg_cnt u_cnt (
    .clk_i, .rst_ni, .restart_i(reload),
    .h_end_i(live[P_HEND]), .v_end_i(live[P_VEND]),
    .h_o(h_cnt), .v_o(v_cnt), .frame_wrap_o(frame_wrap)
  );

  raster_tmg_dec u_dec (
    .h_i(h_cnt), .v_i(v_cnt), .prm_i(live),
    .hsync_o, .vsync_o, .hblank_o, .vblank_o, .de_o, .win_o, .hstep_o, .vstep_o
  );

  always_comb begin
    case (addr_i)
      ADDR_SEL: rdata_o = DW'(sel);
      ADDR_LO:  rdata_o = pend[7:0];
      ADDR_HI:  rdata_o = pend[15:8];
      default:  rdata_o = {6'b0, vblank_o, hblank_o};
    endcase
  end

  assign h_cnt_o = h_cnt;
  assign v_cnt_o = v_cnt;
  assign cols_o  = live[P_COLS];
endmodule

// File: rtl/raster_tmg_chk.sv
module raster_tmg_chk
  import raster_tmg_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reload,
  input logic            frame_wrap,
  input word_t           h_cnt,
  input word_t           v_cnt,
  input word_t           h_end,
  input prm_arr_t        live,
  input logic [SELW-1:0] sel,
  input logic            vsync_o
);
  // R2
  h_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && h_cnt < h_end) |=> (h_cnt == $past(h_cnt) + 16'd1));

  // R2
  h_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && h_cnt >= h_end) |=> (h_cnt == 16'd0));

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (h_cnt == 16'd0 && v_cnt == 16'd0));

  // R9
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && !frame_wrap) |=> $stable(live));

  // R8
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel < SELW'(NPAR));

  // R3
  vsync_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(reload) && !$past(frame_wrap) && v_cnt == $past(v_cnt)) |-> $stable(vsync_o));
endmodule

bind raster_tmg raster_tmg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reload(reload), .frame_wrap(frame_wrap),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .h_end(live[8]), .live(live), .sel(sel),
  .vsync_o(vsync_o)
);

// File: tb/raster_tmg_test.sv
module raster_tmg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [15:0] h_cnt, v_cnt, cols;
  logic hsync, vsync, hblank, vblank, de, win, hstep, vstep;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit run_chk = 1'b0, done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  raster_tmg uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .h_cnt_o(h_cnt), .v_cnt_o(v_cnt),
    .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank), .vblank_o(vblank),
    .de_o(de), .win_o(win), .hstep_o(hstep), .vstep_o(vstep), .cols_o(cols)
  );

  // preset table from R11
  function automatic logic [15:0] pre(input logic [1:0] m, input int i);
    int w[4]  = '{320, 640, 800, 1024};
    int hh[4] = '{200, 480, 600, 768};
    int le[4] = '{511, 799, 1055, 1343};
    int fe[4] = '{259, 524, 627, 805};
    int a[4]  = '{363, 656, 840, 1048};
    int b[4]  = '{408, 752, 968, 1184};
    int c[4]  = '{219, 490, 601, 771};
    int d[4]  = '{223, 492, 605, 777};
    int p[4]  = '{0, 0, 1, 0};
    int x[4]  = '{0, 1, 1, 2};
    int y[4]  = '{0, 1, 2, 2};
    int r;
    case (i)
      1, 3: r = w[m];   5, 7: r = hh[m];  8: r = le[m];  9: r = fe[m];
      10: r = 40;       11: r = a[m];     12: r = b[m];  13: r = c[m];
      14: r = d[m];     15, 16: r = p[m]; 17: r = x[m];  18: r = y[m];
      default: r = 0;
    endcase
    return 16'(r);
  endfunction

  // reference model
  logic [15:0] m_live [19];
  logic [15:0] m_pend [19];
  logic [4:0]  m_sel;
  logic [1:0]  m_mode;
  logic [15:0] m_h, m_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 2'd0; m_sel <= '0; m_h <= '0; m_v <= '0;
      for (int i = 0; i < 19; i++) begin m_live[i] <= pre(2'd0, i); m_pend[i] <= pre(2'd0, i); end
    end else if (mode != m_mode) begin
      m_mode <= mode; m_h <= '0; m_v <= '0;
      for (int i = 0; i < 19; i++) begin m_live[i] <= pre(mode, i); m_pend[i] <= pre(mode, i); end
    end else begin
      if (wr_en) begin
        if (addr == 2'd0 && wdata < 8'd19) m_sel <= wdata[4:0];
        if (addr == 2'd1) m_pend[m_sel][7:0]  <= wdata;
        if (addr == 2'd2) m_pend[m_sel][15:8] <= wdata;
      end
      if (m_h >= m_live[8]) begin
        m_h <= '0;
        if (m_v >= m_live[9]) begin
          m_v <= '0;
          for (int i = 0; i < 19; i++) m_live[i] <= m_pend[i];
        end else m_v <= m_v + 16'd1;
      end else m_h <= m_h + 16'd1;
    end
  end

  function automatic logic [1:0] msk(input logic [15:0] f);
    return (f == 0) ? 2'b00 : (f == 1) ? 2'b01 : 2'b11;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && run_chk) begin
      logic e_hd, e_vd;
      logic [1:0] hm, vm;
      e_hd = m_h >= m_live[0] && m_h < m_live[1];
      e_vd = m_v >= m_live[4] && m_v < m_live[5];
      hm = msk(m_live[17]); vm = msk(m_live[18]);
      check("R2 h_cnt", 32'(h_cnt), 32'(m_h));
      check("R2 v_cnt", 32'(v_cnt), 32'(m_v));
      check("R3 hsync", 32'(hsync), 32'((m_h >= m_live[11] && m_h <= m_live[12]) ? (m_live[15] != 0) : (m_live[15] == 0)));
      check("R3 vsync", 32'(vsync), 32'((m_v >= m_live[13] && m_v <= m_live[14]) ? (m_live[16] != 0) : (m_live[16] == 0)));
      check("R4 hblank", 32'(hblank), 32'(!e_hd));
      check("R4 vblank", 32'(vblank), 32'(!e_vd));
      check("R4 de", 32'(de), 32'(e_hd && e_vd));
      check("R5 win", 32'(win), 32'(m_h >= m_live[2] && m_h < m_live[3] && m_v >= m_live[6] && m_v < m_live[7]));
      check("R6 hstep", 32'(hstep), 32'((m_h[1:0] & hm) == hm));
      check("R6 vstep", 32'(vstep), 32'(m_h == m_live[8] && (m_v[1:0] & vm) == vm));
      check("R6 cols", 32'(cols), 32'(m_live[10]));
      case (addr)
        2'd0: check("R7 rd sel", 32'(rdata), 32'(m_sel));
        2'd1: check("R7 rd lo", 32'(rdata), 32'(m_pend[m_sel][7:0]));
        2'd2: check("R7 rd hi", 32'(rdata), 32'(m_pend[m_sel][15:8]));
        default: check("R7 rd stat", 32'(rdata), {30'd0, !e_vd, !e_hd});
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 2'd3;
  endtask

  task automatic setp(input int i, input logic [15:0] v);
    wr(2'd0, 8'(i)); wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask

  task automatic rdp(input int i, output logic [15:0] v);
    wr(2'd0, 8'(i));
    addr = 2'd1; #1 v[7:0] = rdata;
    @(negedge clk); addr = 2'd2; #1 v[15:8] = rdata;
    @(negedge clk); addr = 2'd3;
  endtask

  task automatic line_len(output int n);
    while (h_cnt != 0) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (h_cnt != 0);
  endtask

  task automatic wait_frame();
    while (v_cnt == 0) @(negedge clk);
    while (!(v_cnt == 0 && h_cnt == 0)) @(negedge clk);
  endtask

  initial begin
    int n;
    logic [15:0] v;
    logic [15:0] sm [19] = '{16'd2, 16'd26, 16'd4, 16'd24, 16'd1, 16'd9, 16'd2, 16'd8, 16'd31, 16'd11,
                             16'd4, 16'd27, 16'd29, 16'd9, 16'd10, 16'd0, 16'd1, 16'd1, 16'd2};
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1; addr = 2'd3;
    #1;
    // R1 reset state
    check("R1 h_cnt", 32'(h_cnt), 0);
    check("R1 v_cnt", 32'(v_cnt), 0);
    addr = 2'd0; #1 check("R1 sel", 32'(rdata), 0);
    addr = 2'd3;
    run_chk = 1'b1;
    for (int i = 0; i < 19; i++) begin
      rdp(i, v);
      check("R1 preset", 32'(v), 32'(pre(2'd0, i)));
    end
    // R9: overrides written mid-frame must not alter the running frame
    for (int i = 0; i < 19; i++) setp(i, sm[i]);
    line_len(n);
    check("R9 old line length", n, 512);
    wait_frame();
    line_len(n);
    check("R9 new line length", n, 32);
    // R8 out-of-range selector ignored
    wr(2'd0, 8'd5); wr(2'd0, 8'd19);
    addr = 2'd0; #1 check("R8 sel 19 ignored", 32'(rdata), 5);
    wr(2'd0, 8'd200);
    addr = 2'd0; #1 check("R8 sel 200 ignored", 32'(rdata), 5);
    // R7 write to status address has no effect
    rdp(5, v);
    wr(2'd3, 8'hff);
    rdp(5, v);
    check("R7 status write ignored", 32'(v), 32'(sm[5]));
    // constrained random overrides
    for (int it = 0; it < 60; it++) begin
      for (int k = 0; k < 4; k++) begin
        int i = $urandom_range(0, 22);
        int lo;
        case (i)
          8: lo = $urandom_range(20, 60);
          9: lo = $urandom_range(6, 20);
          15, 16: lo = $urandom_range(0, 1);
          17, 18: lo = $urandom_range(0, 3);
          default: lo = $urandom_range(0, 70);
        endcase
        wr(2'd0, 8'(i)); wr(2'd1, 8'(lo)); wr(2'd2, 8'd0);
      end
      addr = 2'($urandom_range(0, 3));
      repeat ($urandom_range(50, 600)) @(negedge clk);
      addr = 2'd3;
    end
    // R10 mode change wins over a same-edge write; R11 preset readback
    for (int m = 1; m < 4; m++) begin
      wr(2'd0, 8'd11);
      @(negedge clk); mode = 2'(m); wr_en = 1'b1; addr = 2'd1; wdata = 8'h00;
      @(negedge clk); wr_en = 1'b0; addr = 2'd3;
      check("R10 restart h", 32'(h_cnt), 0);
      check("R10 restart v", 32'(v_cnt), 0);
      for (int i = 0; i < 19; i++) begin
        rdp(i, v);
        check("R11 preset", 32'(v), 32'(pre(2'(m), i)));
      end
      repeat (1500) @(negedge clk);
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (done || cyc >= 195000) begin
      if (!done) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<195000", cyc);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule